// File: doc/BRIEF.md
# Dual-Clock Mode-Selected Shift Register

This block is a four-stage register with two separate strobe lines. A mode input decides which strobe has any effect. In shift mode, a falling edge on the shift line moves every stage one place toward the last stage and takes a new bit from the serial input into the first stage. In load mode, a falling edge on the load line copies all four parallel inputs into the stages at once. The strobe that is not selected has no effect, and the stages keep their contents whenever no selected falling edge arrives.

The whole block runs on a single system clock. Each strobe line and the mode input pass through their own two-flop synchronizer. A falling edge is detected after synchronization and becomes a one-cycle internal pulse. If the synchronized mode value changes in the same cycle that either line's pulse appears, the register is not updated. Instead, a one-cycle error flag is raised, so the data never takes an undefined value.

To shift toward the first stage, use load mode and wire stage outputs 1, 2 and 3 back to parallel inputs 0, 1 and 2. Serial data is then fed into parallel input 3.

Top module: `dual_strobe_shreg`

## Requirements
- R1: A synchronous active-high `rst` clears `q_out` to 0, clears `mode_err` to 0 and clears all synchronizer and edge history, one clock after it is sampled.
- R2: With `mode_sel` = 0, a high-to-low change on `shift_clk_in` sets `q_out[0]` to `ser_in` and `q_out[i]` to the old `q_out[i-1]`. The new value appears on the third rising `clk` edge after the line falls.
- R3: With `mode_sel` = 1, a high-to-low change on `load_clk_in` copies `par_in` into `q_out`, with `par_in[i]` going to `q_out[i]`. The new value appears three rising edges after the line falls.
- R4: A low-to-high change on either strobe line leaves `q_out` unchanged.
- R5: With `mode_sel` = 1, falling edges on `shift_clk_in` are ignored. With `mode_sel` = 0, falling edges on `load_clk_in` are ignored.
- R6: When no selected falling edge occurs, `q_out` holds its value for any number of cycles.
- R7: If the synchronized `mode_sel` changes in the same cycle that a falling edge on either line is detected, `q_out` holds and `mode_err` is 1 for exactly one cycle. That cycle is the one in which the update would otherwise have appeared.
- R8: With `mode_sel` = 1 and `par_in` = {d, `q_out[3]`, `q_out[2]`, `q_out[1]`}, each load-line falling edge moves the contents one place toward `q_out[0]` and puts d into `q_out[3]`. After four edges, `q_out[k]` holds the k-th serial bit applied.
- R9: If both lines fall in the same cycle, only the line selected by `mode_sel` has an effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk_in | input | 1 | Strobe line whose falling edge shifts in shift mode |
| load_clk_in | input | 1 | Strobe line whose falling edge loads in load mode |
| mode_sel | input | 1 | 0 selects shift, 1 selects parallel load |
| ser_in | input | 1 | Serial bit entering stage 0 on a shift |
| par_in | input | WIDTH | Parallel data; bit i goes to stage i on a load |
| q_out | output | WIDTH | Stage contents; bit 0 is the first stage |
| mode_err | output | 1 | One-cycle pulse when a mode change coincides with a strobe edge |

## Verification
The path from a falling strobe line to a new `q_out` is three registers long: two synchronizer flops and the stage register. For this reason, every shift, load, ignored edge and rising edge is given an expected value due three rising edges after the line is driven. A mode conflict raises `mode_err` in that same cycle and clears it one cycle later, and reset takes effect after one edge. The driver stamps each expected item with the due cycle when it queues the item. The monitor compares on the falling `clk` edge of exactly that cycle, and it reports any item it finds overdue.

// File: rtl/dss_pkg.sv
package dss_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic {
        MODE_SHIFT = 1'b0,
        MODE_LOAD  = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_SHIFT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_FAULT = 2'd3
    } act_e;

    // Synchronized view of one external strobe line.
    typedef struct packed {
        logic fell;   // one-cycle pulse on a 1 -> 0 change
        logic level;  // synchronized level
    } line_evt_t;

    // Selected-clock decision for one system cycle.
    function automatic act_e pick_action(input mode_e m, input logic moved,
                                         input logic sh_fall, input logic ld_fall);
        act_e r;
        r = ACT_HOLD;
        if ((sh_fall || ld_fall) && moved)
            r = ACT_FAULT;
        else if (m == MODE_SHIFT && sh_fall)
            r = ACT_SHIFT;
        else if (m == MODE_LOAD && ld_fall)
            r = ACT_LOAD;
        return r;
    endfunction
endpackage

// File: rtl/dss_edge_sync.sv
module dss_edge_sync
    import dss_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      line_in,
    output line_evt_t evt
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] chain;
    logic          prev_level;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= line_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_level <= 1'b0;
        else     prev_level <= chain[LAST];
    end

    always_comb begin
        evt.level = chain[LAST];
        evt.fell  = prev_level & ~chain[LAST];
    end

    // R4: a detected edge is a single-cycle pulse, never a level
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        evt.fell |=> !evt.fell);
endmodule

// File: rtl/dss_mode_guard.sv
module dss_mode_guard
    import dss_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      mode_in,
    input  line_evt_t sh_evt,
    input  line_evt_t ld_evt,
    output act_e      act
);
    timeunit 1ns;
    timeprecision 1ps;

    line_evt_t mode_evt;
    mode_e     mode_now;
    logic      mode_last;
    logic      moved;

    // Same depth as the strobe paths, so mode and edge line up in time.
    dss_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_mode_sync (
        .clk     (clk),
        .rst     (rst),
        .line_in (mode_in),
        .evt     (mode_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) mode_last <= 1'b0;
        else     mode_last <= mode_evt.level;
    end

    always_comb begin
        mode_now = mode_e'(mode_evt.level);
        moved    = mode_evt.level ^ mode_last;
        act      = pick_action(mode_now, moved, sh_evt.fell, ld_evt.fell);
    end

    // R5: a shift is only issued under shift mode, a load only under load mode
    a_r5_shift_in_shift_mode: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_SHIFT) |-> (mode_evt.level == 1'b0 && sh_evt.fell));
    a_r5_load_in_load_mode: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_LOAD) |-> (mode_evt.level == 1'b1 && ld_evt.fell));
endmodule

// File: rtl/dss_stage_bank.sv
module dss_stage_bank
    import dss_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  act_e             act,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q,
    output logic             fault
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TOP = WIDTH - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            fault <= 1'b0;
        end else begin
            fault <= (act == ACT_FAULT);
            unique case (act)
                ACT_SHIFT: q <= {q[TOP-1:0], ser_in};
                ACT_LOAD:  q <= par_in;
                default:   q <= q;
            endcase
        end
    end

    // R1: reset empties the stages and clears the flag
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (q == '0 && !fault));
    // R6: without an action the stages hold
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_HOLD) |=> $stable(q));
    // R2: a shift moves each stage up by one and takes the serial bit
    a_r2_shift_moves: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_SHIFT) |=> (q == {$past(q[TOP-1:0]), $past(ser_in)}));
    // R3: a load copies the parallel word
    a_r3_load_copies: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_LOAD) |=> (q == $past(par_in)));
endmodule

// File: rtl/dual_strobe_shreg.sv
module dual_strobe_shreg
    import dss_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_clk_in,
    input  logic             load_clk_in,
    input  logic             mode_sel,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q_out,
    output logic             mode_err
);
    timeunit 1ns;
    timeprecision 1ps;

    line_evt_t sh_evt;
    line_evt_t ld_evt;
    act_e      act;

    dss_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_shift_sync (
        .clk     (clk),
        .rst     (rst),
        .line_in (shift_clk_in),
        .evt     (sh_evt)
    );

    dss_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_load_sync (
        .clk     (clk),
        .rst     (rst),
        .line_in (load_clk_in),
        .evt     (ld_evt)
    );

    dss_mode_guard #(.SYNC_STAGES(SYNC_STAGES)) u_guard (
        .clk     (clk),
        .rst     (rst),
        .mode_in (mode_sel),
        .sh_evt  (sh_evt),
        .ld_evt  (ld_evt),
        .act     (act)
    );

    dss_stage_bank #(.WIDTH(WIDTH)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .ser_in (ser_in),
        .par_in (par_in),
        .q      (q_out),
        .fault  (mode_err)
    );

    // R7: the cycle that reports a mode conflict carries no data change
    a_r7_fault_freezes: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> $stable(q_out));
    // R9: simultaneous edges never produce both effects; the flag is a pulse
    a_r9_err_pulse: assert property (@(posedge clk) disable iff (rst)
        mode_err |=> !mode_err);
endmodule

// File: tb/dual_strobe_shreg_test.sv
module dss_left_loop #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_line,
    input  logic             ser_d,
    output logic [WIDTH-1:0] q,
    output logic             err
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [WIDTH-1:0] fb;
    assign fb = {ser_d, q[WIDTH-1:1]};   // stage k+1 feeds input k, serial into the top

    dual_strobe_shreg #(.WIDTH(WIDTH)) loop_core (
        .clk          (clk),
        .rst          (rst),
        .shift_clk_in (1'b1),
        .load_clk_in  (ld_line),
        .mode_sel     (1'b1),
        .ser_in       (1'b0),
        .par_in       (fb),
        .q_out        (q),
        .mode_err     (err)
    );
endmodule

module dual_strobe_shreg_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LAT = 3;   // two sync flops + stage register

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sh_line = 1'b1;
    logic       ld_line = 1'b1;
    logic       mode = 1'b0;
    logic       ser = 1'b0;
    logic [3:0] par = 4'h0;
    logic [3:0] q;
    logic       err;
    logic       loop_ld = 1'b1;
    logic       loop_d = 1'b0;
    logic [3:0] loop_q;
    logic       loop_err;

    int cyc = 0;
    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        int         due;
        logic [3:0] q;
        logic       err;
        string      tag;
        bit         loop;
    } exp_t;

    exp_t sb[$];
    logic [3:0] model = 4'h0;
    logic [3:0] lmodel = 4'h0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dual_strobe_shreg #(.WIDTH(4)) uut (
        .clk          (clk),
        .rst          (rst),
        .shift_clk_in (sh_line),
        .load_clk_in  (ld_line),
        .mode_sel     (mode),
        .ser_in       (ser),
        .par_in       (par),
        .q_out        (q),
        .mode_err     (err)
    );

    dss_left_loop #(.WIDTH(4)) loop_uut (
        .clk     (clk),
        .rst     (rst),
        .ld_line (loop_ld),
        .ser_d   (loop_d),
        .q       (loop_q),
        .err     (loop_err)
    );

    // Monitor: compares each queued item in its due cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            logic [3:0] aq;
            logic       ae;
            e = sb.pop_front();
            aq = e.loop ? loop_q : q;
            ae = e.loop ? loop_err : err;
            n_vec++;
            if (e.due != cyc || aq !== e.q || ae !== e.err) begin
                n_bad++;
                $display("FAIL %s: cycle %0d q=%h err=%b, expected cycle %0d q=%h err=%b",
                         e.tag, cyc, aq, ae, e.due, e.q, e.err);
            end
        end
    end

    task automatic expect_in(int delay, logic [3:0] eq, logic ee, string tag, bit lp = 0);
        exp_t e;
        e.due = cyc + delay; e.q = eq; e.err = ee; e.tag = tag; e.loop = lp;
        sb.push_back(e);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Drop one or both lines, then raise them; model per requirements.
    task automatic strobe(bit sh, bit ld, string tag);
        @(negedge clk);
        if (sh) sh_line = 1'b0;
        if (ld) ld_line = 1'b0;
        if (mode == 1'b0 && sh)      model = {model[2:0], ser};
        else if (mode == 1'b1 && ld) model = par;
        expect_in(LAT, model, 1'b0, tag);
        idle(4);
        sh_line = 1'b1;
        ld_line = 1'b1;
        expect_in(LAT, model, 1'b0, "R4 rising edge no change");
        idle(5);
    endtask

    task automatic loop_step(logic d);
        @(negedge clk);
        loop_d = d;
        idle(2);
        loop_ld = 1'b0;
        lmodel = {d, lmodel[3:1]};
        expect_in(LAT, lmodel, 1'b0, "R8 left step", 1);
        idle(4);
        loop_ld = 1'b1;
        idle(4);
    endtask

    initial begin
        #(50000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual run still busy, expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        expect_in(0, 4'h0, 1'b0, "R1 reset state");
        idle(4);

        // R2: shift a pattern in under shift mode
        ser = 1'b1; strobe(1, 0, "R2 shift 1");
        ser = 1'b0; strobe(1, 0, "R2 shift 0");
        ser = 1'b1; strobe(1, 0, "R2 shift 1b");
        ser = 1'b1; strobe(1, 0, "R2 shift 1c");

        // R5: load line ignored in shift mode
        par = 4'h6; strobe(0, 1, "R5 load ignored in shift mode");

        // R9: both lines together in shift mode
        ser = 1'b0; strobe(1, 1, "R9 both lines shift mode");

        // switch to load mode well away from any edge
        @(negedge clk); mode = 1'b1; idle(6);

        // R3: parallel loads
        par = 4'hA; strobe(0, 1, "R3 load A");
        par = 4'h5; strobe(0, 1, "R3 load 5");

        // R5: shift line ignored in load mode
        ser = 1'b1; strobe(1, 0, "R5 shift ignored in load mode");

        // R6: long hold with no edges
        expect_in(20, model, 1'b0, "R6 hold");
        idle(25);

        // R9: both lines together in load mode
        par = 4'hC; strobe(1, 1, "R9 both lines load mode");

        // R7: mode change in the same cycle as a falling edge
        par = 4'h3;
        @(negedge clk);
        mode = 1'b0;
        ld_line = 1'b0;
        expect_in(LAT, model, 1'b1, "R7 conflict flag");
        expect_in(LAT + 1, model, 1'b0, "R7 flag clears");
        idle(5);
        ld_line = 1'b1;
        idle(6);
        ser = 1'b0; strobe(1, 0, "R7 normal after conflict");

        // R1: reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        model = 4'h0;
        expect_in(1, 4'h0, 1'b0, "R1 mid-run reset");
        idle(3);
        rst = 1'b0;
        idle(5);

        // R8: left shift through external feedback
        loop_step(1'b1);
        loop_step(1'b0);
        loop_step(1'b0);
        loop_step(1'b1);
        expect_in(1, 4'b1001, 1'b0, "R8 four steps serial order", 1);
        idle(4);

        idle(10);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d items left, expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule